// File: doc/BRIEF.md
# Repeat-Loop and Trap Next-PC Sequencer

This block decides where a wide-issue core fetches next after each executed instruction bundle. A zero-overhead repeat loop is set by three things: a start address, an end address, and a repeat counter together with a repeat-active status bit. The block branches back at the loop end and decrements the counter there. Explicit jumps take priority over the loop. After the loop bookkeeping is done, the block also handles an instruction-address debug breakpoint and a maskable external interrupt. The interrupt has room for one held request.

For each instruction boundary, the core pulses `stepValid` and presents:
- the executed address,
- the branch outcome,
- the loop registers and the status word as they were before execution,
- any counter write made by the instruction itself.

One clock later the block presents the next PC, the new counter and the new status word. It also updates the saved debug copy of PC and status, or the saved interrupt copy, whenever one of those events occurs.

Top module: `rptloop_pcseq`

## Requirements
- R1: After reset, every output is zero and no interrupt is held.
- R2: Whether the loop branches back depends on the counter value before execution. A counter write made by the instruction does not change that decision, although the written value becomes the output counter.
- R3: At the loop end, when the counter is nonzero or repeat-active is set, the counter drops by one. It saturates at zero and never wraps. Elsewhere the counter is passed through unchanged.
- R4: Status bit positions are: 0 stack select, 1 exception flag, 2 debug enable, 3 debug active, 4 interrupt enable, 5 repeat active. Repeat-active is cleared when it was set, the PC is at the loop end, and the counter after the step is zero.
- R5: The next PC is chosen in this order. A taken branch goes to its target. Otherwise the loop start is used when repeat-active was set, the pre-execution count was nonzero and the PC was the loop end. Otherwise the next PC is the PC plus 8.
- R6: When the executed PC equals the breakpoint address and debug enable is set, four things happen. The sequenced next PC is saved as the debug PC. The loop-updated status word, with the exception flag set, is saved as the debug status. The status keeps only stack select and gains debug active. The next PC becomes 0xFFFFF128.
- R7: With interrupt enable set, an interrupt request causes three things. The post-debug status and next PC are saved in the backup copies. The status becomes zero. The next PC becomes 0xFFFFF138.
- R8: A request that arrives while interrupts are masked is held and re-evaluated at each later step. It is delivered once interrupt enable is seen. Further requests are discarded while one is held.
- R9: A debug entry in a step clears interrupt enable for that step, so an interrupt in the same step is held rather than delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stepValid | input | 1 | One executed instruction boundary this cycle |
| curPc | input | 32 | Address of the executed bundle |
| branchTaken | input | 1 | The bundle performed a jump |
| branchTarget | input | 32 | Jump destination |
| loopStart | input | 32 | Repeat loop first address |
| loopEnd | input | 32 | Repeat loop last address |
| cntIn | input | 32 | Repeat counter before execution |
| cntWrEn | input | 1 | The bundle wrote the repeat counter |
| cntWrVal | input | 32 | Value written by the bundle |
| statusIn | input | 32 | Status word before the step |
| bkptAddr | input | 32 | Debug breakpoint address |
| intReq | input | 1 | External interrupt request |
| pcOut | output | 32 | Next PC |
| cntOut | output | 32 | Updated repeat counter |
| statusOut | output | 32 | Updated status word |
| dbgPc | output | 32 | Saved PC at debug entry |
| dbgStatus | output | 32 | Saved status at debug entry |
| bkPc | output | 32 | Saved PC at interrupt delivery |
| bkStatus | output | 32 | Saved status at interrupt delivery |

## Verification
The assertions assume that every input is stable while `stepValid` is high. They also assume that the inputs describe one consistent bundle: the loop and breakpoint addresses are fixed for that step, and the status word is the one the core actually holds.

The stimulus drives each step for exactly one cycle, with all inputs changed at the falling edge. Interrupt requests are raised only together with a step and are dropped when the step ends. The stimulus also keeps the breakpoint address away from the loop end, except in steps that test each rule on its own.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int ST_SM = 0;  // stack select
  localparam int ST_EA = 1;  // exception flag
  localparam int ST_DB = 2;  // debug enable
  localparam int ST_DS = 3;  // debug active
  localparam int ST_IE = 4;  // interrupt enable
  localparam int ST_RP = 5;  // repeat active

  typedef struct packed {
    logic decCnt;
    logic rpClear;
    logic takeLoop;
    logic useBranch;
    logic dbgEntry;
    logic intDeliver;
  } seqStrobes_t;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int ST_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stepValid,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] loopEnd,
  input  logic [ADDR_W-1:0] bkptAddr,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrVal,
  input  logic [ST_W-1:0]   statusIn,
  input  logic              branchTaken,
  input  logic              intReq,
  output seqStrobes_t       strb,
  output logic              intPending
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic atEnd, rpSet, cntNz, postZero, pendQ;

  always_comb begin
    atEnd = (curPc == loopEnd);
    rpSet = statusIn[ST_RP];
    // R2: nonzero test taken on the pre-execution value
    cntNz = (cntIn != '0);
    strb.decCnt    = atEnd && (cntNz || rpSet);
    if (cntWrEn)          postZero = (cntWrVal == '0);
    else if (strb.decCnt) postZero = (cntIn <= CNT_ONE);
    else                  postZero = !cntNz;
    strb.rpClear    = rpSet && atEnd && postZero;
    strb.useBranch  = branchTaken;
    strb.takeLoop   = !branchTaken && rpSet && cntNz && atEnd;
    strb.dbgEntry   = (curPc == bkptAddr) && statusIn[ST_DB];
    // R9: debug entry masks interrupts for this step
    strb.intDeliver = stepValid && statusIn[ST_IE] && !strb.dbgEntry
                      && (intReq || pendQ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               pendQ <= 1'b0;
    else if (strb.intDeliver) pendQ <= 1'b0;
    else if (intReq)          pendQ <= 1'b1;
  end

  assign intPending = pendQ;

  // R8: a masked request is kept for a later step
  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && intReq && !statusIn[ST_IE]) |=> intPending);

  // R8: delivery consumes the held request
  a_r8_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    strb.intDeliver |=> !intPending);
endmodule

// File: rtl/pcseq_dpath.sv
module pcseq_dpath
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int ST_W   = 32,
  parameter int STEP_BYTES = 8,
  parameter logic [ADDR_W-1:0] DBG_VEC = 32'hFFFF_F128,
  parameter logic [ADDR_W-1:0] INT_VEC = 32'hFFFF_F138
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stepValid,
  input  seqStrobes_t       strb,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic [ADDR_W-1:0] loopStart,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrVal,
  input  logic [ST_W-1:0]   statusIn,
  output logic [ADDR_W-1:0] pcOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic [ST_W-1:0]   statusOut,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [ST_W-1:0]   dbgStatus,
  output logic [ADDR_W-1:0] bkPc,
  output logic [ST_W-1:0]   bkStatus
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP_BYTES);
  localparam logic [ST_W-1:0] KEEP_DBG = ST_W'(1) << ST_SM;
  localparam logic [ST_W-1:0] DS_BIT   = ST_W'(1) << ST_DS;
  localparam logic [ST_W-1:0] EA_BIT   = ST_W'(1) << ST_EA;

  logic [CNT_W-1:0]  decVal, postCnt;
  logic [ADDR_W-1:0] seqPc, dbgNextPc, finPc;
  logic [ST_W-1:0]   loopSt, dbgSnap, dbgNextSt, finSt;

  always_comb begin
    decVal  = (strb.decCnt && cntIn != '0) ? cntIn - CNT_W'(1) : cntIn;
    postCnt = cntWrEn ? cntWrVal : decVal;
    if (strb.useBranch)     seqPc = branchTarget;
    else if (strb.takeLoop) seqPc = loopStart;
    else                    seqPc = curPc + INC;
    loopSt = statusIn;
    if (strb.rpClear) loopSt[ST_RP] = 1'b0;
    dbgSnap   = loopSt | EA_BIT;
    dbgNextSt = strb.dbgEntry ? ((loopSt & KEEP_DBG) | DS_BIT) : loopSt;
    dbgNextPc = strb.dbgEntry ? DBG_VEC : seqPc;
    finSt     = strb.intDeliver ? '0 : dbgNextSt;
    finPc     = strb.intDeliver ? INT_VEC : dbgNextPc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcOut <= '0; cntOut <= '0; statusOut <= '0;
      dbgPc <= '0; dbgStatus <= '0; bkPc <= '0; bkStatus <= '0;
    end else if (stepValid) begin
      pcOut     <= finPc;
      cntOut    <= postCnt;
      statusOut <= finSt;
      if (strb.dbgEntry) begin
        dbgPc     <= seqPc;
        dbgStatus <= dbgSnap;
      end
      if (strb.intDeliver) begin
        bkPc     <= dbgNextPc;
        bkStatus <= dbgNextSt;
      end
    end
  end

  // R3: counter never wraps upward
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && !cntWrEn) |=> cntOut <= $past(cntIn));

  // R5: loop-back goes to the loop start
  a_r5_loop_target: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && strb.takeLoop && !strb.dbgEntry && !strb.intDeliver)
      |=> pcOut == $past(loopStart));

  // R6: debug entry vector and status
  a_r6_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && strb.dbgEntry)
      |=> pcOut == DBG_VEC && statusOut[ST_DS] && dbgStatus[ST_EA]);

  // R7: interrupt vector and cleared status
  a_r7_int_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && strb.intDeliver) |=> pcOut == INT_VEC && statusOut == '0);
endmodule

// File: rtl/rptloop_pcseq.sv
module rptloop_pcseq
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int ST_W   = 32,
  parameter int STEP_BYTES = 8,
  parameter logic [ADDR_W-1:0] DBG_VEC = 32'hFFFF_F128,
  parameter logic [ADDR_W-1:0] INT_VEC = 32'hFFFF_F138
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stepValid,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              branchTaken,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic [ADDR_W-1:0] loopStart,
  input  logic [ADDR_W-1:0] loopEnd,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrVal,
  input  logic [ST_W-1:0]   statusIn,
  input  logic [ADDR_W-1:0] bkptAddr,
  input  logic              intReq,
  output logic [ADDR_W-1:0] pcOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic [ST_W-1:0]   statusOut,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [ST_W-1:0]   dbgStatus,
  output logic [ADDR_W-1:0] bkPc,
  output logic [ST_W-1:0]   bkStatus
);
  seqStrobes_t strb;
  logic intPending;

  pcseq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ST_W(ST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stepValid(stepValid), .curPc(curPc),
    .loopEnd(loopEnd), .bkptAddr(bkptAddr), .cntIn(cntIn),
    .cntWrEn(cntWrEn), .cntWrVal(cntWrVal), .statusIn(statusIn),
    .branchTaken(branchTaken), .intReq(intReq), .strb(strb),
    .intPending(intPending));

  pcseq_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ST_W(ST_W),
                .STEP_BYTES(STEP_BYTES), .DBG_VEC(DBG_VEC),
                .INT_VEC(INT_VEC)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stepValid(stepValid), .strb(strb),
    .curPc(curPc), .branchTarget(branchTarget), .loopStart(loopStart),
    .cntIn(cntIn), .cntWrEn(cntWrEn), .cntWrVal(cntWrVal),
    .statusIn(statusIn), .pcOut(pcOut), .cntOut(cntOut),
    .statusOut(statusOut), .dbgPc(dbgPc), .dbgStatus(dbgStatus),
    .bkPc(bkPc), .bkStatus(bkStatus));

  // R5: a jump wins over the loop-back
  a_r5_branch_first: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && branchTaken && !strb.dbgEntry && !strb.intDeliver)
      |=> pcOut == $past(branchTarget));
endmodule

// File: tb/rptloop_pcseq_bench.sv
module rptloop_pcseq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LS = 32'h100, LE = 32'h120, BP = 32'h300;
  localparam logic [31:0] DBGV = 32'hFFFF_F128, INTV = 32'hFFFF_F138;
  localparam logic [31:0] SM = 32'h01, EA = 32'h02, DB = 32'h04, DS = 32'h08,
                          IE = 32'h10, RP = 32'h20;

  logic clk = 0, rst_n = 0, stepValid = 0, branchTaken = 0, cntWrEn = 0, intReq = 0;
  logic [31:0] curPc = 0, branchTarget = 0, cntIn = 0, cntWrVal = 0, statusIn = 0;
  logic [31:0] pcOut, cntOut, statusOut, dbgPc, dbgStatus, bkPc, bkStatus;

  typedef struct {
    logic [31:0] pc, cnt, st, dpc, dst, bpc, bst;
    string tag;
  } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  logic [31:0] mDpc = 0, mDst = 0, mBpc = 0, mBst = 0;
  logic mPend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rptloop_pcseq u_rptloop_pcseq (
    .clk(clk), .rst_n(rst_n), .stepValid(stepValid), .curPc(curPc),
    .branchTaken(branchTaken), .branchTarget(branchTarget), .loopStart(LS),
    .loopEnd(LE), .cntIn(cntIn), .cntWrEn(cntWrEn), .cntWrVal(cntWrVal),
    .statusIn(statusIn), .bkptAddr(BP), .intReq(intReq), .pcOut(pcOut),
    .cntOut(cntOut), .statusOut(statusOut), .dbgPc(dbgPc),
    .dbgStatus(dbgStatus), .bkPc(bkPc), .bkStatus(bkStatus));

  task automatic step(input logic [31:0] pc, input logic br, input logic [31:0] tgt,
                      input logic [31:0] cnt, input logic we, input logic [31:0] wv,
                      input logic [31:0] st, input logic req, input string tag);
    exp_t e;
    logic atEnd, rp, nz, dec, dbg, ie, del;
    logic [31:0] c, p, s;
    atEnd = (pc == LE); rp = st[5]; nz = (cnt != 0);
    dec = atEnd && (nz || rp);
    c = (dec && nz) ? cnt - 1 : cnt;
    if (we) c = wv;
    s = st;
    if (rp && atEnd && c == 0) s[5] = 1'b0;
    p = br ? tgt : ((rp && nz && atEnd) ? LS : pc + 8);
    dbg = (pc == BP) && st[2];
    if (dbg) begin
      mDpc = p; mDst = s | EA; s = (s & SM) | DS; p = DBGV;
    end
    ie = s[4];
    del = ie && (req || mPend);
    if (del) begin
      mBpc = p; mBst = s; s = 0; p = INTV; mPend = 0;
    end else if (req) mPend = 1;
    e.pc = p; e.cnt = c; e.st = s; e.dpc = mDpc; e.dst = mDst;
    e.bpc = mBpc; e.bst = mBst; e.tag = tag;
    @(negedge clk);
    curPc = pc; branchTaken = br; branchTarget = tgt; cntIn = cnt;
    cntWrEn = we; cntWrVal = wv; statusIn = st; intReq = req; stepValid = 1;
    @(posedge clk); #1;
    stepValid = 0; intReq = 0;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if ({pcOut, cntOut, statusOut, dbgPc, dbgStatus, bkPc, bkStatus} !==
          {e.pc, e.cnt, e.st, e.dpc, e.dst, e.bpc, e.bst}) begin
        bad++;
        $display("FAIL %s: got pc=%h cnt=%h st=%h dpc=%h dst=%h bpc=%h bst=%h exp pc=%h cnt=%h st=%h dpc=%h dst=%h bpc=%h bst=%h",
          e.tag, pcOut, cntOut, statusOut, dbgPc, dbgStatus, bkPc, bkStatus,
          e.pc, e.cnt, e.st, e.dpc, e.dst, e.bpc, e.bst);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    if ({pcOut, cntOut, statusOut, dbgPc, dbgStatus, bkPc, bkStatus} !== '0) begin
      bad++; $display("FAIL R1 reset: got pc=%h st=%h exp zeros", pcOut, statusOut);
    end
    step(32'h200, 0, 0, 5, 0, 0, 0, 0, "R5 sequential");
    step(32'h200, 1, 32'h400, 5, 0, 0, 0, 0, "R5 branch");
    step(LE, 0, 0, 3, 0, 0, RP, 0, "R5 loop back R3 dec");
    step(LE, 0, 0, 1, 0, 0, RP, 0, "R4 last pass clears repeat");
    step(LE, 0, 0, 0, 0, 0, RP, 0, "R3 saturate at zero");
    step(LE, 1, 32'h500, 2, 0, 0, RP, 0, "R5 branch over loop");
    step(LE, 0, 0, 3, 1, 0, RP, 0, "R2 pre-execution sample");
    step(LE, 0, 0, 4, 0, 0, 0, 0, "R3 dec without repeat");
    step(32'h110, 0, 0, 7, 0, 0, RP, 0, "R3 no dec off end");
    step(BP, 0, 0, 2, 0, 0, DB | SM | IE | RP, 0, "R6 debug entry");
    step(BP, 0, 0, 2, 0, 0, SM, 0, "R6 debug disabled");
    step(32'h240, 0, 0, 0, 0, 0, IE | RP, 1, "R7 interrupt");
    step(32'h248, 0, 0, 0, 0, 0, 0, 1, "R8 masked hold");
    step(32'h250, 0, 0, 0, 0, 0, 0, 1, "R8 second discarded");
    step(32'h258, 0, 0, 0, 0, 0, IE, 0, "R8 delivered later");
    step(32'h260, 0, 0, 0, 0, 0, IE, 0, "R8 only once");
    step(BP, 0, 0, 0, 0, 0, DB | IE, 1, "R9 debug masks interrupt");
    step(32'h270, 0, 0, 0, 0, 0, IE, 0, "R9 held then delivered");
    step(LE, 0, 0, 6, 1, 9, RP, 0, "R2 write value kept");
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule